// File: doc/BRIEF.md
# Stereo Soft Mute Ramp with Zero-Run Detector

This block sits in a digital audio path just ahead of a stereo delta-sigma modulator. Once per audio frame, marked by a one-cycle frame strobe, it scales a left and a right 24-bit signed sample by a shared gain. The gain moves linearly between unity and silence. While the mute request is high the gain steps downward each frame. While it is low the gain steps back up. A reversal partway through a ramp starts from whatever gain was reached, so no jump is audible.

A speed selector sets the step size, and with it the ramp length: 1024, 2048 or 4096 frames for a full swing. A separate detector watches the raw input samples. It raises a flag once both channels have held exactly zero for a long unbroken run of frames. It lowers the flag in the same frame in which any non-zero sample arrives.

Top module: `audio_soft_mute`

## Requirements
- R1: Reset (active low) clears both output samples and the zero flag to 0, sets the gain to unity and clears the zero-run count, so the first frame after reset passes its samples through unchanged.
- R2: At unity gain each output sample equals its input sample bit for bit. Outputs are registered on the frame strobe and change in the clock cycle that follows it. Each frame uses the gain held before that frame's own ramp step.
- R3: With speed_sel = 2'b00 and the mute request high, the gain falls by 1/1024 of unity per frame. The 1025th muted frame from unity (index 1024) is the first to produce zero output.
- R4: With speed_sel = 2'b01 the step is halved, giving 2048 frames for a full swing. With speed_sel = 2'b10 or 2'b11 the step is quartered, giving 4096 frames.
- R5: When the mute request drops before silence is reached, the gain climbs back from its present value at the same per-frame step. It stops at unity.
- R6: Below unity, an output sample is the input times gain/4096, with the fraction truncated toward zero. The gain runs 0..4096.
- R7: At zero gain both outputs are exactly zero, and the gain stays at zero for as long as the mute request stays high.
- R8: The zero flag rises in the frame in which both inputs have been zero for the 8192nd consecutive frame.
- R9: Any frame with a non-zero left or right input drops the zero flag in that frame and restarts the run count from zero.
- R10: The zero-run count saturates, so the flag stays high for any run of zero frames longer than 8192.
- R11: Cycles without a frame strobe change neither the gain, the outputs nor the zero flag, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame |
| mute_req | input | 1 | High ramps toward silence, low ramps toward unity |
| speed_sel | input | 2 | Ramp speed: 00 normal, 01 double, 10/11 quad |
| left_in | input | 24 | Left input sample, two's complement |
| right_in | input | 24 | Right input sample, two's complement |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |
| zero_flag | output | 1 | High after a long run of all-zero input frames |

## Verification
The hardest state to reach is a ramp reversal from an intermediate gain that is not on the grid of a full swing. The return trip must then be timed exactly to the frame at which unity comes back. The stimulus reaches it by first muting to silence, then releasing for 512 frames, then muting again for 100 frames before the final release. The first pass-through frame is then expected exactly 612 frames later. The saturation of the zero-run count is also out of easy reach, because it needs more than 16384 zero frames before a wrapping counter would show itself. The bench therefore drives an 8192-frame run followed by 8300 further zero frames.

// File: rtl/smr_pkg.sv
package smr_pkg;
  // ramp speed encodings seen on speed_sel
  localparam logic [1:0] SPD_NORMAL   = 2'b00;
  localparam logic [1:0] SPD_DOUBLE   = 2'b01;
  localparam logic [1:0] SPD_QUAD     = 2'b10;
  localparam logic [1:0] SPD_QUAD_ALT = 2'b11;
  // channel count of the stereo path
  localparam int NUM_CH = 2;
endpackage

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp #(
  parameter int GAIN_FRAC   = 12,
  parameter int NORMAL_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_stb,
  input  logic                 mute_req,
  input  logic [1:0]           speed_sel,
  output logic [GAIN_FRAC:0]   gain_o
);
  import smr_pkg::*;

  localparam int            GW     = GAIN_FRAC + 1;
  localparam logic [GW-1:0] UNITY  = GW'(1 << GAIN_FRAC);
  localparam logic [GW-1:0] STEP_N = GW'(NORMAL_STEP);
  localparam logic [GW-1:0] STEP_D = GW'(NORMAL_STEP / 2);
  localparam logic [GW-1:0] STEP_Q = GW'(NORMAL_STEP / 4);

  logic [GW-1:0] gain_q;
  logic [GW-1:0] gain_d;
  logic [GW-1:0] step;
  logic          gain_en;

  always_comb begin
    unique case (speed_sel)
      SPD_NORMAL: step = STEP_N;
      SPD_DOUBLE: step = STEP_D;
      SPD_QUAD, SPD_QUAD_ALT: step = STEP_Q;
      default:    step = STEP_Q;
    endcase
  end

  assign gain_en = frame_stb;

  always_comb begin
    gain_d = gain_q;
    if (mute_req) begin
      if (gain_q > step) gain_d = gain_q - step;
      else               gain_d = '0;
    end else begin
      if (gain_q >= UNITY - step) gain_d = UNITY;
      else                        gain_d = gain_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= UNITY;
    else if (gain_en) gain_q <= gain_d;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int SAMPLE_W  = 24,
  parameter int GAIN_FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_stb,
  input  logic [SAMPLE_W-1:0]  sample_i,
  input  logic [GAIN_FRAC:0]   gain_i,
  output logic [SAMPLE_W-1:0]  sample_o
);
  localparam int                 GW     = GAIN_FRAC + 1;
  localparam int                 PROD_W = SAMPLE_W + GW + 1;
  localparam logic [GW-1:0]      UNITY  = GW'(1 << GAIN_FRAC);
  localparam logic [PROD_W-1:0]  BIAS   = PROD_W'((1 << GAIN_FRAC) - 1);

  logic signed [PROD_W-1:0] samp_ext;
  logic signed [PROD_W-1:0] gain_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;
  logic [SAMPLE_W-1:0]      scaled;
  logic [SAMPLE_W-1:0]      out_d;
  logic [SAMPLE_W-1:0]      out_q;
  logic                     out_en;

  always_comb begin
    samp_ext = {{(PROD_W - SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
    gain_ext = {{(PROD_W - GW){1'b0}}, gain_i};
    prod     = samp_ext * gain_ext;
    // negative products get a bias so the shift truncates toward zero
    biased   = prod + (prod[PROD_W-1] ? BIAS : '0);
    shifted  = biased >>> GAIN_FRAC;
    scaled   = shifted[SAMPLE_W-1:0];
  end

  always_comb begin
    if (gain_i == UNITY)   out_d = sample_i;
    else if (gain_i == '0) out_d = '0;
    else                   out_d = scaled;
  end

  assign out_en = frame_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  assign sample_o = out_q;
endmodule

// File: rtl/smr_zero_detect.sv
module smr_zero_detect #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_stb,
  input  logic [SAMPLE_W-1:0]  left_i,
  input  logic [SAMPLE_W-1:0]  right_i,
  output logic                 zero_o
);
  localparam int               CNT_W   = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] CNT_TRG = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_d;
  logic             flag_q;
  logic             flag_d;
  logic             both_zero;
  logic             run_en;

  assign both_zero = (left_i == '0) && (right_i == '0);
  assign run_en    = frame_stb;

  always_comb begin
    if (!both_zero)           run_d = '0;
    else if (run_q == CNT_MAX) run_d = run_q;
    else                      run_d = run_q + 1'b1;
  end

  assign flag_d = both_zero && (run_q >= CNT_TRG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else if (run_en) begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign zero_o = flag_q;
endmodule

// File: rtl/audio_soft_mute.sv
module audio_soft_mute #(
  parameter int SAMPLE_W    = 24,
  parameter int GAIN_FRAC   = 12,
  parameter int NORMAL_STEP = 4,
  parameter int RUN_LEN     = 8192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_stb,
  input  logic                 mute_req,
  input  logic [1:0]           speed_sel,
  input  logic [SAMPLE_W-1:0]  left_in,
  input  logic [SAMPLE_W-1:0]  right_in,
  output logic [SAMPLE_W-1:0]  left_out,
  output logic [SAMPLE_W-1:0]  right_out,
  output logic                 zero_flag
);
  import smr_pkg::*;

  logic [GAIN_FRAC:0]  gain_q;
  logic [SAMPLE_W-1:0] ch_in  [NUM_CH];
  logic [SAMPLE_W-1:0] ch_out [NUM_CH];

  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  smr_gain_ramp #(
    .GAIN_FRAC  (GAIN_FRAC),
    .NORMAL_STEP(NORMAL_STEP)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .mute_req (mute_req),
    .speed_sel(speed_sel),
    .gain_o   (gain_q)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    smr_scaler #(
      .SAMPLE_W (SAMPLE_W),
      .GAIN_FRAC(GAIN_FRAC)
    ) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .sample_i (ch_in[ch]),
      .gain_i   (gain_q),
      .sample_o (ch_out[ch])
    );
  end

  smr_zero_detect #(
    .SAMPLE_W(SAMPLE_W),
    .RUN_LEN (RUN_LEN)
  ) u_zero (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .left_i   (left_in),
    .right_i  (right_in),
    .zero_o   (zero_flag)
  );

  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int SAMPLE_W  = 24,
  parameter int GAIN_FRAC = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_stb,
  input logic                mute_req,
  input logic [SAMPLE_W-1:0] left_in,
  input logic [SAMPLE_W-1:0] right_in,
  input logic [SAMPLE_W-1:0] left_out,
  input logic [SAMPLE_W-1:0] right_out,
  input logic                zero_flag,
  input logic [GAIN_FRAC:0]  gain
);
  localparam logic [GAIN_FRAC:0] UNITY = (GAIN_FRAC+1)'(1 << GAIN_FRAC);

  assert_gain_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= UNITY);

  assert_mute_nonrising_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && mute_req |=> gain <= $past(gain));

  assert_release_nonfalling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && !mute_req |=> gain >= $past(gain));

  assert_unity_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && gain == UNITY |=> left_out == $past(left_in) && right_out == $past(right_in));

  assert_silent_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && gain == '0 |=> left_out == '0 && right_out == '0);

  assert_flag_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && (left_in != '0 || right_in != '0) |=> !zero_flag);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(gain) && $stable(left_out) && $stable(right_out) && $stable(zero_flag));
endmodule

bind audio_soft_mute smr_checker #(
  .SAMPLE_W (SAMPLE_W),
  .GAIN_FRAC(GAIN_FRAC)
) u_smr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_stb(frame_stb),
  .mute_req (mute_req),
  .left_in  (left_in),
  .right_in (right_in),
  .left_out (left_out),
  .right_out(right_out),
  .zero_flag(zero_flag),
  .gain     (gain_q)
);

// File: tb/audio_soft_mute_tb.sv
module audio_soft_mute_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int UNITY      = 4096;
  localparam int RUN        = 8192;

  typedef struct packed {
    logic        mute;
    logic [23:0] l;
    logic [23:0] r;
    logic [23:0] el;
    logic [23:0] er;
  } vec_t;

  // sequence from reset, normal speed; expected values per R2 and R6
  localparam vec_t VEC [0:7] = '{
    '{1'b0, 24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA},
    '{1'b1, 24'h000001, 24'hFFFFFF, 24'h000001, 24'hFFFFFF},
    '{1'b1, 24'h001000, 24'hFFF000, 24'h000FFC, 24'hFFF004},
    '{1'b0, 24'hFFF000, 24'h001000, 24'hFFF008, 24'h000FF8},
    '{1'b0, 24'hFFFFFF, 24'h000001, 24'h000000, 24'h000000},
    '{1'b0, 24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000},
    '{1'b1, 24'h800000, 24'h7FFFFF, 24'h800000, 24'h7FFFFF},
    '{1'b1, 24'h800000, 24'h7FFFFF, 24'h802000, 24'h7FDFFF}
  };

  logic        clk;
  logic        rst_n;
  logic        frame_stb;
  logic        mute_req;
  logic [1:0]  speed_sel;
  logic [23:0] left_in, right_in, left_out, right_out;
  logic        zero_flag;

  int checks;
  int fails;

  int          mdl_gain;
  int          mdl_run;
  logic [23:0] exp_l, exp_r, act_l, act_r;
  logic        exp_z, act_z;
  int          mis;
  logic [23:0] mis_act, mis_exp;

  audio_soft_mute dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .mute_req (mute_req),
    .speed_sel(speed_sel),
    .left_in  (left_in),
    .right_in (right_in),
    .left_out (left_out),
    .right_out(right_out),
    .zero_flag(zero_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mdl_scale(input logic [23:0] s, input int g);
    longint p;
    p = longint'($signed(s)) * longint'(g);
    p = p / 4096;
    return p[23:0];
  endfunction

  function automatic int mdl_step();
    if (speed_sel == 2'b00) return 4;
    if (speed_sel == 2'b01) return 2;
    return 1;
  endfunction

  task automatic do_frame(input logic m, input logic [23:0] l, input logic [23:0] r);
    int st;
    @(negedge clk);
    mute_req  = m;
    left_in   = l;
    right_in  = r;
    frame_stb = 1'b1;
    exp_l = mdl_scale(l, mdl_gain);
    exp_r = mdl_scale(r, mdl_gain);
    st = mdl_step();
    if (m) mdl_gain = (mdl_gain > st) ? mdl_gain - st : 0;
    else   mdl_gain = (mdl_gain + st >= UNITY) ? UNITY : mdl_gain + st;
    if (l == 24'h0 && r == 24'h0) mdl_run = (mdl_run < RUN) ? mdl_run + 1 : RUN;
    else                          mdl_run = 0;
    exp_z = (mdl_run >= RUN);
    @(negedge clk);
    frame_stb = 1'b0;
    act_l = left_out;
    act_r = right_out;
    act_z = zero_flag;
    if (act_l !== exp_l || act_r !== exp_r) begin
      if (mis == 0) begin
        mis_act = (act_l !== exp_l) ? act_l : act_r;
        mis_exp = (act_l !== exp_l) ? exp_l : exp_r;
      end
      mis++;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    mdl_gain = UNITY;
    mdl_run  = 0;
    chk(left_out == 24'h0 && right_out == 24'h0, "R1 outputs cleared", {left_out, right_out}, 0);
    chk(zero_flag == 1'b0, "R1 flag cleared", zero_flag, 0);
    rst_n = 1'b1;
  endtask

  // run frames of a fixed input until first occurrence of target output
  task automatic ramp_until(input logic m, input logic [23:0] in, input logic [23:0] target,
                            input int max_frames, output int first_idx);
    first_idx = -1;
    for (int i = 0; i < max_frames; i++) begin
      do_frame(m, in, in);
      if (first_idx < 0 && act_l == target) first_idx = i;
    end
  endtask

  initial begin
    checks = 0; fails = 0; mis = 0;
    mdl_gain = UNITY; mdl_run = 0;
    frame_stb = 1'b0; mute_req = 1'b0; speed_sel = 2'b00;
    left_in = '0; right_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(left_out == 24'h0 && right_out == 24'h0, "R1 outputs at reset", {left_out, right_out}, 0);
    chk(zero_flag == 1'b0, "R1 flag at reset", zero_flag, 0);
    rst_n = 1'b1;

    // vector table: R2 pass-through and R6 rounding
    for (int v = 0; v < 8; v++) begin
      do_frame(VEC[v].mute, VEC[v].l, VEC[v].r);
      chk(act_l == VEC[v].el, "R6 table left", act_l, VEC[v].el);
      chk(act_r == VEC[v].er, "R2 table right", act_r, VEC[v].er);
    end

    // R1: reset in mid-ramp restores unity
    apply_reset();
    do_frame(1'b0, 24'h2A2A2A, 24'hD5D5D5);
    chk(act_l == 24'h2A2A2A && act_r == 24'hD5D5D5, "R1 unity after reset", act_l, 24'h2A2A2A);

    // R3: normal-speed mute reaches silence at frame 1024
    begin
      int idx;
      mis = 0;
      speed_sel = 2'b00;
      ramp_until(1'b1, 24'h100000, 24'h0, 1100, idx);
      chk(idx == 1024, "R3 normal mute length", idx, 1024);
      chk(mis == 0, "R6 ramp samples", mis_act, mis_exp);
    end

    // R7: stays silent while mute held
    begin
      int nz;
      nz = 0;
      for (int i = 0; i < 16; i++) begin
        do_frame(1'b1, 24'h7FFFFF, 24'h800000);
        if (act_l != 24'h0 || act_r != 24'h0) nz++;
      end
      chk(nz == 0, "R7 silence held", nz, 0);
    end

    // R5: partial reversal from an intermediate gain
    begin
      int idx;
      mis = 0;
      for (int i = 0; i < 512; i++) do_frame(1'b0, 24'h100000, 24'hF00000);
      for (int i = 0; i < 100; i++) do_frame(1'b1, 24'h100000, 24'hF00000);
      ramp_until(1'b0, 24'h100000, 24'h100000, 700, idx);
      chk(idx == 612, "R5 return to unity frame", idx, 612);
      chk(mis == 0, "R5 reversal samples", mis_act, mis_exp);
    end

    // R4: double and quad speed lengths
    begin
      int idx;
      mis = 0;
      speed_sel = 2'b01;
      ramp_until(1'b1, 24'h100000, 24'h0, 2100, idx);
      chk(idx == 2048, "R4 double mute length", idx, 2048);
      speed_sel = 2'b10;
      ramp_until(1'b0, 24'h100000, 24'h100000, 4100, idx);
      chk(idx == 4096, "R4 quad release length", idx, 4096);
      speed_sel = 2'b11;
      for (int i = 0; i < 10; i++) do_frame(1'b1, 24'h001000, 24'h001000);
      chk(act_l == 24'h000FF7, "R4 quad alt step", act_l, 24'h000FF7);
      chk(mis == 0, "R4 speed samples", mis_act, mis_exp);
    end

    // R11: idle cycles change nothing
    begin
      logic [23:0] hl, hr;
      int moved;
      speed_sel = 2'b00;
      mis = 0;
      for (int i = 0; i < 3; i++) do_frame(1'b1, 24'h003000, 24'h003000);
      hl = left_out; hr = right_out;
      moved = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        mute_req = i[0];
        speed_sel = i[1:0];
        left_in = 24'h0;
        right_in = 24'h0;
        if (left_out != hl || right_out != hr || zero_flag != 1'b0) moved++;
      end
      speed_sel = 2'b00;
      chk(moved == 0, "R11 outputs held", moved, 0);
      do_frame(1'b1, 24'h003000, 24'h003000);
      chk(mis == 0, "R11 gain held", mis_act, mis_exp);
    end

    // R8/R9/R10: zero-run detector
    begin
      int first_hi, lows;
      first_hi = -1;
      for (int i = 0; i < RUN; i++) begin
        do_frame(1'b0, 24'h0, 24'h0);
        if (first_hi < 0 && act_z) first_hi = i;
      end
      chk(first_hi == RUN - 1, "R8 flag rise frame", first_hi, RUN - 1);
      lows = 0;
      for (int i = 0; i < 8300; i++) begin
        do_frame(1'b0, 24'h0, 24'h0);
        if (!act_z) lows++;
      end
      chk(lows == 0, "R10 flag stays high", lows, 0);
      do_frame(1'b0, 24'h000010, 24'h0);
      chk(act_z == 1'b0, "R9 left nonzero drops flag", act_z, 0);
      first_hi = -1;
      for (int i = 0; i < RUN; i++) begin
        do_frame(1'b0, 24'h0, 24'h0);
        if (first_hi < 0 && act_z) first_hi = i;
      end
      chk(first_hi == RUN - 1, "R9 run restarted", first_hi, RUN - 1);
      do_frame(1'b0, 24'h0, 24'hFFFFFF);
      chk(act_z == 1'b0, "R9 right nonzero drops flag", act_z, 0);
      chk(act_z == exp_z, "R8 model agreement", act_z, exp_z);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule